// File: doc/BRIEF.md
# Presettable Binary Up/Down Counter with Terminal-Count Outputs

A small binary counter, 4 bits wide by default, that counts up or down on the rising clock edge. A single direction input selects the direction. An active-low enable gates counting. While an active-low load input is held LOW, the register takes the data inputs at once, without waiting for a clock edge. The load takes priority over counting and follows any change on the data inputs for as long as it stays LOW.

The block has two carry/borrow indications. The terminal-count flag is a level decode of the state and the direction: it is HIGH at the all-ones state when counting up and at zero when counting down. The ripple output is active-low. It passes the LOW phase of the clock through while terminal count is HIGH and counting is enabled. Wider counters are built by chaining instances. One method feeds each stage's enable from the AND of the terminal counts of all lower stages. The other uses the ripple output of one stage as the clock or enable of the next stage.

Top module: `updown_counter4`

## Requirements
- R1: While load_n is LOW, q equals din within the same time step with no clock edge, and it follows every later change of din.
- R2: When cnt_en_n is HIGH, a rising clock edge leaves q unchanged.
- R3: When cnt_en_n is LOW, each rising clock edge adds one to q (dir_down = 0) or subtracts one from q (dir_down = 1), modulo 2^WIDTH. This means 15 goes to 0 when counting up and 0 goes to 15 when counting down.
- R4: term is HIGH exactly when q is all ones with dir_down = 0, or q is zero with dir_down = 1. It is LOW otherwise.
- R5: term changes when only dir_down changes, with no clock edge, and the value of cnt_en_n has no effect on it.
- R6: ripple_n is LOW only while clk is LOW, term is HIGH and cnt_en_n is LOW. In every other case it is HIGH, so it rises together with the clock.
- R7: Four instances that share one clock form a 16-bit counter that wraps correctly in both directions. In this arrangement each stage's enable is the global enable ORed with the inverted AND of the term outputs of all lower stages.
- R8: A load held LOW across a rising clock edge with counting enabled keeps q at din.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| cnt_en_n | input | 1 | Count enable, active LOW |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous parallel load, active LOW |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Counter state |
| term | output | 1 | Terminal-count flag |
| ripple_n | output | 1 | Gated clock for cascading, active LOW |

## Verification
The bench builds every instance with the default WIDTH of 4. At this width all 16 states in both directions fit in a short run, so it sweeps every start value and checks the following edge, the wrap and the terminal-count decode. A second group of four default instances forms a 16-bit chain. This chain brings the carry and borrow across all three stage boundaries within reach of a few dozen cycles.

// File: rtl/updown_counter4.sv
module updown_counter4 #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             cnt_en_n,
  input  logic             dir_down,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             term,
  output logic             ripple_n
);
  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] step;

  assign step = dir_down ? state - WIDTH'(1) : state + WIDTH'(1);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic set_n, clr_n, b;
    assign set_n = load_n | ~din[i];
    assign clr_n = load_n | din[i];
    always_ff @(posedge clk or negedge set_n or negedge clr_n) begin
      if (!clr_n)         b <= 1'b0;
      else if (!set_n)    b <= 1'b1;
      else if (!cnt_en_n) b <= step[i];
    end
    assign state[i] = b;
  end

  assign q        = state;
  assign term     = dir_down ? (state == '0) : (&state);
  assign ripple_n = ~(~clk & term & ~cnt_en_n);
endmodule

module updown_counter4_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             cnt_en_n,
  input logic             dir_down,
  input logic             load_n,
  input logic [WIDTH-1:0] q,
  input logic             term
);
  logic ld_seen;
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) ld_seen <= 1'b1;
    else         ld_seen <= 1'b0;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!load_n)
    cnt_en_n |=> (ld_seen || q == $past(q)));

  assert_up_R3: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && !dir_down) |=> (ld_seen || q == WIDTH'($past(q) + WIDTH'(1))));

  assert_down_R3: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && dir_down) |=> (ld_seen || q == WIDTH'($past(q) - WIDTH'(1))));

  assert_top_term_R4: assert property (@(posedge clk) disable iff (!load_n)
    (!dir_down && q == '1) |-> term);

  assert_bottom_term_R4: assert property (@(posedge clk) disable iff (!load_n)
    (dir_down && q == '0) |-> term);

  assert_idle_term_R4: assert property (@(posedge clk) disable iff (!load_n)
    (q != '0 && q != '1) |-> !term);
endmodule

bind updown_counter4 updown_counter4_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .cnt_en_n(cnt_en_n), .dir_down(dir_down),
  .load_n(load_n), .q(q), .term(term)
);

// File: tb/updown_counter4_test.sv
`timescale 1ns/1ps
module updown_counter4_test;
  logic clk = 1'b0;
  logic en_n = 1'b1, dn = 1'b0, ld_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] q;
  logic term, rip_n;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  updown_counter4 uut (.clk(clk), .cnt_en_n(en_n), .dir_down(dn), .load_n(ld_n),
                       .din(din), .q(q), .term(term), .ripple_n(rip_n));

  logic g_en_n = 1'b1, g_dn = 1'b0, g_ld_n = 1'b1;
  logic [15:0] g_din = 16'd0;
  logic [15:0] c_q;
  logic [3:0] c_term, c_rip;
  logic [4:0] carry;
  assign carry[0] = 1'b1;
  for (genvar k = 0; k < 4; k++) begin : g_stage
    assign carry[k+1] = carry[k] & c_term[k];
    updown_counter4 st (.clk(clk), .cnt_en_n(g_en_n | ~carry[k]), .dir_down(g_dn),
                        .load_n(g_ld_n), .din(g_din[4*k +: 4]), .q(c_q[4*k +: 4]),
                        .term(c_term[k]), .ripple_n(c_rip[k]));
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic preset(input logic [3:0] v);
    din = v; ld_n = 1'b0; #1; ld_n = 1'b1; #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [15:0] exp16;
    tick();
    // R1: asynchronous load, following din while held low
    ld_n = 1'b0; din = 4'd9; #1;
    chk("R1 load immediate", q, 9);
    #3 din = 4'd6; #1;
    chk("R1 load follows din", q, 6);
    // R8: load held across an enabled edge
    en_n = 1'b0; dn = 1'b0;
    tick();
    chk("R8 load priority", q, 6);
    ld_n = 1'b1; en_n = 1'b1; #1;
    chk("R1 released value", q, 6);

    // R3/R4: sweep every start value in both directions
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 16; s++) begin
        dn = d[0]; en_n = 1'b0;
        preset(s[3:0]);
        chk(d ? "R4 term down" : "R4 term up", term,
            (d == 0 && s == 15) || (d == 1 && s == 0));
        tick();
        chk(d ? "R3 count down" : "R3 count up", q, d ? ((s + 15) % 16) : ((s + 1) % 16));
      end
    end

    // R2: enable high holds
    en_n = 1'b1; dn = 1'b0; preset(4'd5);
    tick(); tick();
    chk("R2 hold", q, 5);
    // R5: term follows direction alone and ignores enable
    preset(4'd15);
    chk("R5 term up at 15", term, 1);
    dn = 1'b1; #1;
    chk("R5 term after dir flip", term, 0);
    preset(4'd0);
    chk("R5 term down at 0 enable high", term, 1);
    en_n = 1'b0; #1;
    chk("R5 term down at 0 enable low", term, 1);
    dn = 1'b0; #1;
    chk("R5 term dir back up", term, 0);

    // R6: ripple gating
    en_n = 1'b1; preset(4'd15);
    @(negedge clk); #1;
    chk("R6 ripple blocked by enable", rip_n, 1);
    en_n = 1'b0; #1;
    chk("R6 ripple low phase", rip_n, 0);
    @(posedge clk); #1;
    chk("R6 ripple rises with clock", rip_n, 1);
    chk("R3 wrap to 0", q, 0);
    @(negedge clk); #1;
    chk("R6 ripple idle when term low", rip_n, 1);
    #2;

    // R7: 16-bit cascade
    tick();
    g_dn = 1'b0; g_en_n = 1'b0; g_din = 16'hFFFE;
    g_ld_n = 1'b0; #1; g_ld_n = 1'b1; #1;
    exp16 = 16'hFFFE;
    for (int i = 0; i < 4; i++) begin
      tick(); exp16 = exp16 + 16'd1;
      chk("R7 cascade up", c_q, exp16);
    end
    g_din = 16'h0101; g_dn = 1'b1;
    g_ld_n = 1'b0; #1; g_ld_n = 1'b1; #1;
    exp16 = 16'h0101;
    for (int i = 0; i < 3; i++) begin
      tick(); exp16 = exp16 - 16'd1;
      chk("R7 cascade down", c_q, exp16);
    end
    g_din = 16'h0000; g_ld_n = 1'b0; #1; g_ld_n = 1'b1; #1;
    exp16 = 16'h0000;
    tick(); exp16 = exp16 - 16'd1;
    chk("R7 cascade borrow wrap", c_q, exp16);
    g_din = 16'h00F0; g_dn = 1'b0;
    g_ld_n = 1'b0; #1; g_ld_n = 1'b1; #1;
    exp16 = 16'h00F0;
    for (int i = 0; i < 20; i++) begin
      tick(); exp16 = exp16 + 16'd1;
      chk("R7 cascade carry", c_q, exp16);
    end
    g_en_n = 1'b1;
    tick(); tick();
    chk("R2 cascade hold", c_q, exp16);

    finish_run();
  end
endmodule